// File: doc/BRIEF.md
# Muxed Programmable Frequency Generator Bank

This block holds six programmable clock generators. Each one picks one of three source clocks, divides it by a ratio taken from a control field, and can be switched off. The sources are a core clock and two auxiliary PLL clocks. The block itself runs on a fast system clock. It receives each source as a level that is already synchronous to that clock, counts the rising edges of the selected source, and produces each generator output as a registered level.

The control state is two 32-bit words that software writes through a synchronous write port and reads back through a registered read port. Each word carries three 10-bit generator fields. A mode input chooses how the fields are read:

- **Legacy mode:** a one-bit source choice, a separate enable bit, and ratios that are always even.
- **Extended mode:** a two-bit source code in which zero switches the generator off, and a per-word scale flag that allows any integer ratio, including a straight pass-through.

A change of ratio is held back until the running output period ends, so that no runt pulse is produced.

Top module: `fgen_bank`

## Requirements
- R1: After reset, both control words read back as zero and all six outputs are low.
- R2: A write to word `wr_idx` stores `wr_data` exactly. Reading that word afterwards returns the same 32 bits. Read data appears one clock after `rd_idx` is presented.
- R3: Generator i uses word i/3, at bit offset 10*(i mod 3). Its 8-bit divide value N sits at field bits [9:2]. In legacy mode the ratio is (N+1)*2 source periods, and the output is high for the first half of each period.
- R4: In legacy mode, field bit 0 selects the source: 0 picks the core clock and 1 picks the first auxiliary clock.
- R5: In legacy mode, field bit 1 enables the generator. When it is 0, the output stays low.
- R6: In legacy mode, clearing the enable bit and then setting it again, with bit 0 unchanged, resumes the output from the same source at the same ratio.
- R7: In extended mode, source code 0 in field bits [1:0] switches the generator off, and its output stays low.
- R8: In extended mode, codes 1, 2 and 3 select the second auxiliary clock, the core clock and the first auxiliary clock respectively.
- R9: In extended mode with the word's bit 30 set, the ratio is N+1. For an odd ratio r, the output is high for floor(r/2) source periods out of r.
- R10: In extended mode with bit 30 clear, the ratio is (N+1)*2. Each word's bit 30 governs only that word's three generators.
- R11: A ratio of 1 gives an output that follows the selected source: high for half a source period, with a period of one source period.
- R12: In legacy mode, bit 30 has no effect on the ratio.
- R13: When a generator's ratio is rewritten while it runs, the period in progress completes with the old ratio, and the new ratio starts at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 0 = legacy field layout, 1 = extended field layout |
| src_lvl | input | 3 | Source levels: bit 0 core clock, bit 1 first auxiliary clock, bit 2 second auxiliary clock |
| wr_en | input | 1 | Write strobe for the control words |
| wr_idx | input | 1 | Index of the control word to write |
| wr_data | input | 32 | Write data |
| rd_idx | input | 1 | Index of the control word to read |
| rd_data | output | 32 | Registered read data |
| gen_out | output | 6 | Generator outputs, one bit per generator |

## Verification
The source clocks run with distinct periods of 2, 4 and 6 system cycles. Because of this, the measured output period shows which source a generator actually picked as well as the ratio it applied. High-time measurements separate even from odd ratios and confirm the pass-through at ratio 1. Directed cases cover the following:

- legacy and extended source maps;
- the scale flag in both modes and in both words;
- disable followed by re-enable;
- a ratio rewritten in the middle of a period, which must not show a mixed-length period.

A seeded random sweep over generator, mode, source code, scale and small divide values then checks period and high time against bench-computed ratios.

// File: rtl/fgen_pkg.sv
`timescale 1ns/1ps
package fgen_pkg;
  typedef enum logic [1:0] {
    SRC_CORE = 2'd0,
    SRC_AUXA = 2'd1,
    SRC_AUXB = 2'd2
  } src_e;
  localparam int SRC_COUNT = 3;
endpackage

// File: rtl/fgen_regs.sv
`timescale 1ns/1ps
module fgen_regs #(
  parameter int NUM_REGS = 2,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [IDX_W-1:0]           rd_idx,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] mem [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) mem[wr_idx] <= wr_data;
      rd_data <= mem[rd_idx];
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs_flat[i*DATA_W +: DATA_W] = mem[i];
  end
endmodule

// File: rtl/fgen_decode.sv
`timescale 1ns/1ps
module fgen_decode #(
  parameter int FIELD_W = 10,
  parameter int DIV_W   = 8,
  parameter int RATIO_W = DIV_W + 2
) (
  input  logic               ext_mode,
  input  logic               scale,
  input  logic [FIELD_W-1:0] fld,
  output logic               en,
  output fgen_pkg::src_e     src,
  output logic [RATIO_W-1:0] ratio
);
  import fgen_pkg::*;
  logic [DIV_W-1:0]   nval;
  logic [RATIO_W-1:0] base;

  always_comb begin
    nval = fld[DIV_W+1:2];
    base = {{(RATIO_W-DIV_W){1'b0}}, nval} + RATIO_W'(1);
    if (ext_mode) begin
      en = (fld[1:0] != 2'd0);
      unique case (fld[1:0])
        2'd1:    src = SRC_AUXB;
        2'd2:    src = SRC_CORE;
        default: src = SRC_AUXA;
      endcase
      ratio = scale ? base : (base << 1);
    end else begin
      en    = fld[1];
      src   = fld[0] ? SRC_AUXA : SRC_CORE;
      ratio = base << 1;
    end
  end
endmodule

// File: rtl/fgen_chan.sv
`timescale 1ns/1ps
module fgen_chan #(
  parameter int RATIO_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               src_lvl,
  input  logic               src_edge,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               out_q,
  output logic [RATIO_W-1:0] cnt_q,
  output logic [RATIO_W-1:0] cur_q
);
  logic               wrap;
  logic [RATIO_W-1:0] nxt_cnt;
  logic [RATIO_W-1:0] nxt_cur;

  always_comb begin
    wrap    = src_edge && (cnt_q == cur_q - RATIO_W'(1));
    nxt_cur = wrap ? ratio_in : cur_q;
    if (!src_edge)  nxt_cnt = cnt_q;
    else if (wrap)  nxt_cnt = '0;
    else            nxt_cnt = cnt_q + RATIO_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      cur_q <= ratio_in;
      out_q <= 1'b0;
    end else begin
      cnt_q <= nxt_cnt;
      cur_q <= nxt_cur;
      out_q <= (nxt_cur == RATIO_W'(1)) ? src_lvl : (nxt_cnt < (nxt_cur >> 1));
    end
  end
endmodule

// File: rtl/fgen_bank.sv
`timescale 1ns/1ps
module fgen_bank #(
  parameter int NUM_GEN     = 6,
  parameter int GEN_PER_REG = 3,
  parameter int DATA_W      = 32,
  parameter int FIELD_W     = 10,
  parameter int DIV_W       = 8,
  parameter int SCALE_BIT   = 30,
  parameter int NUM_REGS    = (NUM_GEN + GEN_PER_REG - 1) / GEN_PER_REG,
  parameter int IDX_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ext_mode,
  input  logic [2:0]           src_lvl,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [DATA_W-1:0]    rd_data,
  output logic [NUM_GEN-1:0]   gen_out
);
  import fgen_pkg::*;
  localparam int RATIO_W = DIV_W + 2;

  logic [NUM_REGS*DATA_W-1:0]  ctl_flat;
  logic [SRC_COUNT-1:0]        src_prev;
  logic [SRC_COUNT-1:0]        src_edge;
  logic [NUM_GEN-1:0]          en_w;
  logic [NUM_GEN-1:0]          sel_edge_w;
  logic [NUM_GEN*RATIO_W-1:0]  cnt_flat;
  logic [NUM_GEN*RATIO_W-1:0]  cur_flat;

  fgen_regs #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .regs_flat(ctl_flat)
  );

  always_ff @(posedge clk) begin
    if (rst) src_prev <= '0;
    else     src_prev <= src_lvl;
  end
  assign src_edge = src_lvl & ~src_prev;

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int RI  = g / GEN_PER_REG;
    localparam int OFF = RI * DATA_W + FIELD_W * (g % GEN_PER_REG);
    src_e               src_w;
    logic [RATIO_W-1:0] ratio_w;

    fgen_decode #(.FIELD_W(FIELD_W), .DIV_W(DIV_W), .RATIO_W(RATIO_W)) dec_i (
      .ext_mode(ext_mode),
      .scale(ctl_flat[RI*DATA_W + SCALE_BIT]),
      .fld(ctl_flat[OFF +: FIELD_W]),
      .en(en_w[g]), .src(src_w), .ratio(ratio_w)
    );

    assign sel_edge_w[g] = src_edge[src_w];

    fgen_chan #(.RATIO_W(RATIO_W)) chan_i (
      .clk(clk), .rst(rst), .en(en_w[g]),
      .src_lvl(src_lvl[src_w]), .src_edge(sel_edge_w[g]),
      .ratio_in(ratio_w), .out_q(gen_out[g]),
      .cnt_q(cnt_flat[g*RATIO_W +: RATIO_W]),
      .cur_q(cur_flat[g*RATIO_W +: RATIO_W])
    );
  end
endmodule

// File: rtl/fgen_bank_chk.sv
`timescale 1ns/1ps
module fgen_bank_chk #(
  parameter int NUM_GEN  = 6,
  parameter int NUM_REGS = 2,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 1,
  parameter int RATIO_W  = 10
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [DATA_W-1:0]          wr_data,
  input logic [NUM_REGS*DATA_W-1:0] ctl_flat,
  input logic [NUM_GEN-1:0]         en_w,
  input logic [NUM_GEN-1:0]         sel_edge_w,
  input logic [NUM_GEN-1:0]         gen_out,
  input logic [NUM_GEN*RATIO_W-1:0] cnt_flat,
  input logic [NUM_GEN*RATIO_W-1:0] cur_flat
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    p_wr_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_idx == IDX_W'(r)) |=> ctl_flat[r*DATA_W +: DATA_W] == $past(wr_data));
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_ch
    // R5 and R7: a disabled generator drives low
    p_off_low_r7: assert property (@(posedge clk) disable iff (rst)
      !en_w[g] |=> !gen_out[g]);

    p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[g*RATIO_W +: RATIO_W] < cur_flat[g*RATIO_W +: RATIO_W]);

    p_ratio_at_boundary_r13: assert property (@(posedge clk) disable iff (rst)
      (en_w[g] && $past(en_w[g]) &&
       cur_flat[g*RATIO_W +: RATIO_W] != $past(cur_flat[g*RATIO_W +: RATIO_W]))
      |-> ($past(sel_edge_w[g]) &&
           $past(cnt_flat[g*RATIO_W +: RATIO_W]) ==
           $past(cur_flat[g*RATIO_W +: RATIO_W]) - RATIO_W'(1)));
  end
endmodule

bind fgen_bank fgen_bank_chk #(
  .NUM_GEN(NUM_GEN), .NUM_REGS(NUM_REGS), .DATA_W(DATA_W),
  .IDX_W(IDX_W), .RATIO_W(DIV_W + 2)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .ctl_flat(ctl_flat), .en_w(en_w), .sel_edge_w(sel_edge_w), .gen_out(gen_out),
  .cnt_flat(cnt_flat), .cur_flat(cur_flat)
);

// File: tb/fgen_bank_tb.sv
`timescale 1ns/1ps
module fgen_bank_tb_top;
  localparam int NG = 6;
  localparam int PER [3] = '{2, 4, 6};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_mode = 1'b0;
  logic [2:0]  src_lvl = 3'b000;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_idx = 1'b0;
  logic [31:0] wr_data = '0;
  logic [0:0]  rd_idx = 1'b0;
  logic [31:0] rd_data;
  logic [NG-1:0] gen_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int last_per [NG];
  int last_hi  [NG];
  int rises    [NG];
  int since    [NG];
  int hi_run   [NG];
  bit ever_high[NG];
  logic [NG-1:0] prev_out = '0;

  fgen_bank dut_i (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .src_lvl(src_lvl),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .gen_out(gen_out)
  );

  always #4 clk = ~clk;

  // source levels, updated away from the active edge
  initial begin
    int sc [3];
    for (int k = 0; k < 3; k++) sc[k] = 0;
    forever begin
      @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        sc[k] = (sc[k] + 1 >= PER[k]) ? 0 : sc[k] + 1;
        src_lvl[k] = (sc[k] < PER[k] / 2);
      end
    end
  end

  // output period / high-time monitor
  initial begin
    for (int g = 0; g < NG; g++) begin
      last_per[g] = 0; last_hi[g] = 0; rises[g] = 0;
      since[g] = 0; hi_run[g] = 0; ever_high[g] = 0;
    end
    forever begin
      @(negedge clk);
      for (int g = 0; g < NG; g++) begin
        if (gen_out[g]) begin
          ever_high[g] = 1;
          hi_run[g]++;
        end else if (prev_out[g]) begin
          last_hi[g] = hi_run[g];
          hi_run[g] = 0;
        end
        if (gen_out[g] && !prev_out[g]) begin
          last_per[g] = since[g];
          since[g] = 1;
          rises[g]++;
        end else begin
          since[g]++;
        end
      end
      prev_out = gen_out;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input int idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 1'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input int idx, output logic [31:0] d);
    @(negedge clk);
    rd_idx = 1'(idx);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_rises(input int g, input int n, input string req);
    int base = rises[g];
    int t = 0;
    while (rises[g] < base + n && t < 5000) begin
      @(negedge clk); #1;
      t++;
    end
    if (t >= 5000) chk(0, {req, " timeout"}, rises[g] - base, n);
  endtask

  task automatic measure(input int g, input int r, input int s, input string req);
    int ep = r * PER[s];
    int eh = (r == 1) ? PER[s] / 2 : (r / 2) * PER[s];
    wait_rises(g, 3, req);
    chk(last_per[g] == ep, {req, " period"}, last_per[g], ep);
    chk(last_hi[g] == eh, {req, " high"}, last_hi[g], eh);
  endtask

  task automatic expect_quiet(input int g, input string req);
    repeat (4) @(negedge clk);
    ever_high[g] = 0;
    repeat (100) @(negedge clk);
    chk(!ever_high[g], req, int'(ever_high[g]), 0);
  endtask

  function automatic logic [31:0] lf(input int s, input int en, input int n);
    return (32'(n) << 2) | (32'(en) << 1) | 32'(s);
  endfunction

  function automatic logic [31:0] ef(input int code, input int n);
    return (32'(n) << 2) | 32'(code);
  endfunction

  function automatic int exp_ratio(input bit ext, input bit sc, input int n);
    return (ext && sc) ? n + 1 : (n + 1) * 2;
  endfunction

  function automatic int src_of(input bit ext, input int code);
    if (!ext) return code;
    return (code == 1) ? 2 : (code == 2) ? 0 : 1;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] a;
    logic [31:0] b;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    read_reg(0, v); chk(v == 0, "R1 word0", v, 0);
    read_reg(1, v); chk(v == 0, "R1 word1", v, 0);
    chk(gen_out == '0, "R1 outputs", int'(gen_out), 0);

    // R2 exact read-back
    a = $urandom; b = $urandom;
    write_reg(0, a); write_reg(1, b);
    read_reg(0, v); chk(v == a, "R2 word0", v, a);
    read_reg(1, v); chk(v == b, "R2 word1", v, b);
    write_reg(1, 32'h0);

    // legacy: R3 ratio 8 on core, R4 aux select, R5 disabled
    ext_mode = 1'b0;
    write_reg(0, lf(0,1,3) | (lf(1,1,0) << 10) | (lf(0,0,1) << 20));
    measure(0, 8, 0, "R3 legacy N=3");
    measure(1, 2, 1, "R4 legacy aux");
    expect_quiet(2, "R5 legacy enable clear");

    // R12 scale bit ignored in legacy mode
    write_reg(0, lf(0,1,3) | (lf(1,1,0) << 10) | (32'h1 << 30));
    measure(0, 8, 0, "R12 legacy scale");

    // R6 disable then re-enable keeps source
    write_reg(0, lf(0,1,3) | (lf(1,0,0) << 10));
    expect_quiet(1, "R6 disabled low");
    write_reg(0, lf(0,1,3) | (lf(1,1,0) << 10));
    measure(1, 2, 1, "R6 resume aux");

    // extended: R7 off, R8 codes, R10 scale clear
    ext_mode = 1'b1;
    write_reg(0, ef(0,5) | (ef(2,2) << 10));
    write_reg(1, ef(1,1) | (ef(2,0) << 10) | (ef(3,2) << 20));
    expect_quiet(0, "R7 code zero");
    measure(3, 4, 2, "R8 code1 auxb");
    measure(4, 2, 0, "R8 code2 core");
    measure(5, 6, 1, "R8 code3 auxa");
    measure(1, 6, 0, "R10 scale clear");

    // R9 odd ratios, R11 pass-through, R10 per-word scale
    write_reg(1, ef(2,2) | (ef(2,0) << 10) | (ef(3,4) << 20) | (32'h1 << 30));
    measure(3, 3, 0, "R9 ratio3");
    measure(4, 1, 0, "R11 ratio1");
    measure(5, 5, 1, "R9 ratio5");
    measure(1, 6, 0, "R10 other word");

    // R13 ratio change waits for boundary
    write_reg(1, ef(2,7) | (32'h1 << 30));
    measure(3, 8, 0, "R13 before");
    wait_rises(3, 1, "R13");
    write_reg(1, ef(2,3) | (32'h1 << 30));
    wait_rises(3, 1, "R13");
    chk(last_per[3] == 16, "R13 old period", last_per[3], 16);
    chk(last_hi[3] == 8, "R13 old high", last_hi[3], 8);
    wait_rises(3, 1, "R13");
    chk(last_per[3] == 8, "R13 new period", last_per[3], 8);
    chk(last_hi[3] == 4, "R13 new high", last_hi[3], 4);

    // random sweep (R3 R8 R9 R10)
    write_reg(0, 32'h0); write_reg(1, 32'h0);
    for (int it = 0; it < 20; it++) begin
      bit ext = 1'($urandom % 2);
      bit sc = 1'($urandom % 2);
      int g = int'($urandom % 6);
      int n = int'($urandom % 8);
      int code = ext ? 1 + int'($urandom % 3) : int'($urandom % 2);
      logic [31:0] fld = ext ? ef(code, n) : lf(code, 1, n);
      ext_mode = ext;
      write_reg(g / 3, (fld << (10 * (g % 3))) | (32'(sc) << 30));
      measure(g, exp_ratio(ext, sc, n), src_of(ext, code), "R3 R9 random");
      write_reg(g / 3, 32'h0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule